// File: doc/BRIEF.md
# Keyed Register Unlock Gate

This block guards the writable registers of a watchdog that sit in a 16-byte memory-mapped window. A protected register can only be changed after software writes a two-value key to the command offset. First it writes 0x80, which arms the gate. Then it writes 0x86, which opens it. The gate then lets exactly one 16-bit or 32-bit write through and closes again without further action. The block is placed between a simple register bus and the watchdog's timer logic. The timer logic is outside this block.

Through the gate, software can load two 20-bit preload values, request a reload, or clear a sticky flag that records that the watchdog caused the last reset. The reload and the clear each produce a one-cycle strobe. The flag is set by the timer logic through a dedicated input. Software reads the flag back at the command offset, where it appears on two bit positions at once so that either position can be tested.

Top module: `keygate_unlock`

## Requirements
- R1: A write of any size to offset 0xC whose size-masked data equals 0x80 arms the gate from any state. The masks are: size code 0 (byte) keeps data bits 7:0, code 1 (halfword) keeps bits 15:0, codes 2 (word) and 3 keep all 32 bits.
- R2: A write to offset 0xC whose masked data equals 0x86 opens the gate only when the gate is armed. While the gate is closed or armed, any other write leaves its state unchanged.
- R3: While the gate is open, a halfword write to offset 0xC with data bit 8 set drives `reload_pulse` high in the cycle after the write.
- R4: While the gate is open, a halfword write to offset 0xC with data bit 9 or bit 12 set clears the flag and drives `clear_pulse` high in the cycle after the write. `cause_set` sets the flag, and a set in the same cycle as a clear wins.
- R5: While the gate is open, a word write to offset 0x0 loads `preload_a`, and one to offset 0x4 loads `preload_b`, with data bits 19:0.
- R6: Any write with size code 1, 2 or 3 made while the gate is open closes the gate, unless it is an arming key. A protected write that follows without a new key has no effect.
- R7: Byte writes (size code 0) never perform a protected action and never close an open gate.
- R8: A halfword read of offset 0xC returns 0x1200 on `rdata` in the cycle after the read when the flag is set, and 0 when it is clear. Every other read, and every cycle without a read, gives 0.
- R9: Reset closes the gate, sets both preloads to 0xFFFFF, clears the flag, and drives both strobes and `rdata` to 0.
- R10: While the gate is open, a write whose size does not fit the action at its offset (halfword at 0x0 or 0x4, word at 0xC) changes no register but still closes the gate.
- R11: Each strobe lasts a single cycle. While the gate is closed or armed, writes to protected offsets change no preload and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | 4 | Byte offset inside the register window |
| wdata | input | 32 | Write data |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved (treated as wide) |
| cause_set | input | 1 | Sets the previous-reset flag |
| rdata | output | 32 | Read data, registered |
| preload_a | output | 20 | First-stage preload value |
| preload_b | output | 20 | Second-stage preload value |
| reload_pulse | output | 1 | One-cycle reload request |
| clear_pulse | output | 1 | One-cycle flag-clear request |

## Verification
The assertions assume that every bus input is a known value whenever reset is released, and that reset is asserted from time zero. The stimulus holds `rst_n` low from the start and drives every input, including idle data, to defined values. It changes inputs only on the falling clock edge. It never issues a read and a write in the same cycle, so the read-back checks depend only on the flag state before the access.

// File: rtl/keygate_pkg.sv
// Package: shared types for the keyed unlock gate.
// Assumes: two-bit size and state encodings, used by every module of the gate.
package keygate_pkg;

    // Gate state: closed, armed after the first key, open after the second key
    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    // Bus access size codes
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

endpackage

// File: rtl/keygate_seq.sv
// Module: keygate_seq
// Tracks the unlock state. The arming key wins from any state. The opening
// key counts only when the gate is armed. Any wide write closes an open gate.
// Assumes: the key-hit inputs already include wr_en and the offset match.
module keygate_seq
    import keygate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       key_arm,
    input  logic       key_open,
    input  logic       wide,
    output key_state_e state,
    output logic       accept
);

    key_state_e state_nx;

    // Next-state selection for the key sequence
    always_comb begin
        state_nx = state;
        if (wr_en) begin
            if (key_arm) begin
                state_nx = KS_ARMED;
            end else if (key_open && state == KS_ARMED) begin
                state_nx = KS_OPEN;
            end else if (state == KS_OPEN && wide) begin
                state_nx = KS_LOCKED;
            end
        end
    end

    // The single write allowed through an open gate
    assign accept = wr_en && wide && (state == KS_OPEN) && !key_arm;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= KS_LOCKED;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/keygate_cmd.sv
// Module: keygate_cmd
// Performs the accepted protected write: loads a preload register or issues
// the reload / clear commands, and registers them into one-cycle strobes.
// Assumes: accept is high for at most one cycle per unlock.
module keygate_cmd
    import keygate_pkg::*;
#(
    parameter int                  ADDR_W  = 4,
    parameter int                  PRE_W   = 20,
    parameter logic [ADDR_W-1:0]   PA_OFF  = 4'h0,
    parameter logic [ADDR_W-1:0]   PB_OFF  = 4'h4,
    parameter logic [ADDR_W-1:0]   CMD_OFF = 4'hC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PRE_W-1:0]  pre_data,
    input  logic              bit_reload,
    input  logic              bit_clear,
    output logic [PRE_W-1:0]  preload_a,
    output logic [PRE_W-1:0]  preload_b,
    output logic              clear_cmd,
    output logic              reload_pulse,
    output logic              clear_pulse
);

    localparam int               N_PRE   = 2;
    localparam logic [PRE_W-1:0] PRE_RST = {PRE_W{1'b1}};

    logic             is_half;
    logic             is_word;
    logic             reload_cmd;
    logic [PRE_W-1:0] pre_q [N_PRE];

    // Size qualifiers for the protected actions
    assign is_half = (size == SZ_HALF);
    assign is_word = (size == SZ_WORD);

    // Command decode at the command offset
    assign reload_cmd = accept && is_half && (addr == CMD_OFF) && bit_reload;
    assign clear_cmd  = accept && is_half && (addr == CMD_OFF) && bit_clear;

    // One preload register per protected offset
    for (genvar g = 0; g < N_PRE; g++) begin : g_pre
        localparam logic [ADDR_W-1:0] MY_OFF = (g == 0) ? PA_OFF : PB_OFF;

        // Load on an accepted word write to this register's offset
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[g] <= PRE_RST;
            end else if (accept && is_word && addr == MY_OFF) begin
                pre_q[g] <= pre_data;
            end
        end
    end

    assign preload_a = pre_q[0];
    assign preload_b = pre_q[1];

    // Strobe registers, high for one cycle after the accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_pulse <= 1'b0;
            clear_pulse  <= 1'b0;
        end else begin
            reload_pulse <= reload_cmd;
            clear_pulse  <= clear_cmd;
        end
    end

endmodule

// File: rtl/keygate_status.sv
// Module: keygate_status
// Holds the previous-reset flag and produces the registered read data.
// Assumes: a set and a clear in the same cycle resolve to set.
module keygate_status #(
    parameter int                DATA_W   = 32,
    parameter logic [DATA_W-1:0] READ_VAL = 32'h0000_1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cause_set,
    input  logic              clear_cmd,
    input  logic              rd_en,
    input  logic              rd_hit,
    output logic [DATA_W-1:0] rdata
);

    logic flag_q;

    // Sticky flag: set by the timer side, cleared by command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (cause_set) begin
            flag_q <= 1'b1;
        end else if (clear_cmd) begin
            flag_q <= 1'b0;
        end
    end

    // Read data register, zero unless a flag read hits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= (rd_en && rd_hit && flag_q) ? READ_VAL : '0;
        end
    end

endmodule

// File: rtl/keygate_unlock.sv
// Module: keygate_unlock (top)
// Decodes the key values and the command fields from the bus, and connects the
// sequencer, the protected-write logic and the status register.
// Assumes: wr_en and rd_en are not both high in one cycle. Byte writes are
// compared with the key on bits 7:0 only.
module keygate_unlock
    import keygate_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 32,
    parameter int                PRE_W      = 20,
    parameter logic [ADDR_W-1:0] PA_OFF     = 4'h0,
    parameter logic [ADDR_W-1:0] PB_OFF     = 4'h4,
    parameter logic [ADDR_W-1:0] CMD_OFF    = 4'hC,
    parameter logic [DATA_W-1:0] KEY_ARM    = 32'h80,
    parameter logic [DATA_W-1:0] KEY_OPEN   = 32'h86,
    parameter int                RELOAD_BIT = 8,
    parameter int                CLR_BIT_A  = 9,
    parameter int                CLR_BIT_B  = 12,
    parameter logic [DATA_W-1:0] READ_VAL   = 32'h0000_1200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        size,
    input  logic              cause_set,
    output logic [DATA_W-1:0] rdata,
    output logic [PRE_W-1:0]  preload_a,
    output logic [PRE_W-1:0]  preload_b,
    output logic              reload_pulse,
    output logic              clear_pulse
);

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    key_state_e        key_state;
    logic [DATA_W-1:0] wval;
    logic              at_cmd;
    logic              key_arm;
    logic              key_open;
    logic              wide;
    logic              accept;
    logic              clear_cmd;
    logic              rd_hit;

    // Mask the write data to the access size before the key compare
    always_comb begin
        case (size)
            SZ_BYTE: wval = {{(DATA_W-BYTE_W){1'b0}}, wdata[BYTE_W-1:0]};
            SZ_HALF: wval = {{(DATA_W-HALF_W){1'b0}}, wdata[HALF_W-1:0]};
            default: wval = wdata;
        endcase
    end

    // Key and size decode
    assign at_cmd   = (addr == CMD_OFF);
    assign key_arm  = wr_en && at_cmd && (wval == KEY_ARM);
    assign key_open = wr_en && at_cmd && (wval == KEY_OPEN);
    assign wide     = (size != SZ_BYTE);
    assign rd_hit   = at_cmd && (size == SZ_HALF);

    keygate_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .key_arm  (key_arm),
        .key_open (key_open),
        .wide     (wide),
        .state    (key_state),
        .accept   (accept)
    );

    keygate_cmd #(
        .ADDR_W  (ADDR_W),
        .PRE_W   (PRE_W),
        .PA_OFF  (PA_OFF),
        .PB_OFF  (PB_OFF),
        .CMD_OFF (CMD_OFF)
    ) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .size         (size),
        .addr         (addr),
        .pre_data     (wdata[PRE_W-1:0]),
        .bit_reload   (wdata[RELOAD_BIT]),
        .bit_clear    (wdata[CLR_BIT_A] | wdata[CLR_BIT_B]),
        .preload_a    (preload_a),
        .preload_b    (preload_b),
        .clear_cmd    (clear_cmd),
        .reload_pulse (reload_pulse),
        .clear_pulse  (clear_pulse)
    );

    keygate_status #(
        .DATA_W   (DATA_W),
        .READ_VAL (READ_VAL)
    ) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_set (cause_set),
        .clear_cmd (clear_cmd),
        .rd_en     (rd_en),
        .rd_hit    (rd_hit),
        .rdata     (rdata)
    );

endmodule

// File: rtl/keygate_unlock_chk.sv
// Module: keygate_unlock_chk
// Temporal checks on the gate, bound to the top module.
// Assumes: reset is low from time zero and inputs are known once it is released.
module keygate_unlock_chk
    import keygate_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter int                DATA_W   = 32,
    parameter int                PRE_W    = 20,
    parameter logic [ADDR_W-1:0] CMD_OFF  = 4'hC,
    parameter logic [DATA_W-1:0] KEY_ARM  = 32'h80,
    parameter logic [DATA_W-1:0] READ_VAL = 32'h0000_1200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [1:0]        size,
    input logic [1:0]        key_state,
    input logic              reload_pulse,
    input logic              clear_pulse,
    input logic [PRE_W-1:0]  preload_a,
    input logic [PRE_W-1:0]  preload_b,
    input logic [DATA_W-1:0] rdata
);

    logic live;
    logic arm_hit;

    // Marks that one full cycle has passed since reset was released
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Arming key seen on the bus, with the size masks applied
    always_comb begin
        case (size)
            SZ_BYTE: arm_hit = (wdata[7:0] == KEY_ARM[7:0]);
            SZ_HALF: arm_hit = (wdata[15:0] == KEY_ARM[15:0]);
            default: arm_hit = (wdata == KEY_ARM);
        endcase
        arm_hit = arm_hit && wr_en && (addr == CMD_OFF);
    end

    p_reset_closes_r9: assert property (@(posedge clk)
        !rst_n |=> key_state == KS_LOCKED);

    p_arm_any_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit |=> key_state == KS_ARMED);

    p_open_via_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        live && key_state == KS_OPEN |->
            ($past(key_state) == KS_ARMED || $past(key_state) == KS_OPEN));

    p_reload_from_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live && reload_pulse |-> $past(key_state) == KS_OPEN && $past(wr_en));

    p_wide_consumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_state == KS_OPEN && wr_en && size != SZ_BYTE && !arm_hit
            |=> key_state == KS_LOCKED);

    p_byte_keeps_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        key_state == KS_OPEN && wr_en && size == SZ_BYTE && !arm_hit
            |=> key_state == KS_OPEN);

    p_rdata_values_r8: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (rdata == '0 || rdata == READ_VAL));

    p_reload_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        live && reload_pulse |=> !reload_pulse);

    p_clear_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        live && clear_pulse |=> !clear_pulse);

    p_closed_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        live && key_state != KS_OPEN |=> $stable(preload_a) && $stable(preload_b));

endmodule

bind keygate_unlock keygate_unlock_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PRE_W    (PRE_W),
    .CMD_OFF  (CMD_OFF),
    .KEY_ARM  (KEY_ARM),
    .READ_VAL (READ_VAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .size         (size),
    .key_state    (key_state),
    .reload_pulse (reload_pulse),
    .clear_pulse  (clear_pulse),
    .preload_a    (preload_a),
    .preload_b    (preload_b),
    .rdata        (rdata)
);

// File: tb/keygate_unlock_tb_top.sv
// Bench for keygate_unlock: a table of vectors walked by one loop, then
// directed reset tests. Inputs change on the falling edge. Each vector is
// checked at the next falling edge.
module keygate_unlock_tb_top;

    localparam logic [19:0] F  = 20'hFFFFF;
    localparam logic [19:0] A1 = 20'h12345;
    localparam logic [19:0] A2 = 20'h00333;
    localparam logic [19:0] B1 = 20'h00777;
    localparam logic [19:0] B2 = 20'h00222;
    localparam logic [31:0] RV = 32'h1200;
    localparam logic [1:0]  SB = 2'd0;
    localparam logic [1:0]  SH = 2'd1;
    localparam logic [1:0]  SW = 2'd2;
    localparam logic [3:0]  C  = 4'hC;
    localparam int          NV = 64;

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [1:0]  sz;
        logic [3:0]  ad;
        logic [31:0] dt;
        logic        st;
        logic        er;
        logic        ec;
        logic [31:0] erd;
        logic [19:0] epa;
        logic [19:0] epb;
        logic [3:0]  rq;
    } vec_t;

    // wr rd sz ad dt set | reload clear rdata pa pb | requirement
    localparam vec_t TBL [NV] = '{
        '{0,0,SB,0,32'h0,1, 0,0,0, F,F, 4},          // R4 flag set
        '{0,1,SH,C,32'h0,0, 0,0,RV,F,F, 8},          // R8 flag read
        '{0,1,SW,C,32'h0,0, 0,0,0, F,F, 8},          // R8 word read is 0
        '{0,1,SH,0,32'h0,0, 0,0,0, F,F, 8},          // R8 other offset
        '{1,0,SW,0,32'h12345,0, 0,0,0, F,F, 11},     // R11 closed gate
        '{1,0,SH,C,32'h80,0, 0,0,0, F,F, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, F,F, 2},
        '{1,0,SW,0,32'hABC12345,0, 0,0,0, A1,F, 5},  // R5 preload a, low 20 bits
        '{1,0,SW,4,32'h54321,0, 0,0,0, A1,F, 6},     // R6 already consumed
        '{1,0,SB,C,32'h80,0, 0,0,0, A1,F, 1},        // R1 byte key
        '{1,0,SB,C,32'h86,0, 0,0,0, A1,F, 2},
        '{1,0,SB,0,32'h55,0, 0,0,0, A1,F, 7},        // R7 byte does not consume
        '{1,0,SW,4,32'hFFF00777,0, 0,0,0, A1,B1, 7}, // R7 gate still open
        '{1,0,SW,C,32'h80,0, 0,0,0, A1,B1, 1},       // R1 word key
        '{1,0,SW,C,32'h86,0, 0,0,0, A1,B1, 2},
        '{1,0,SH,C,32'h100,0, 1,0,0, A1,B1, 3},      // R3 reload strobe
        '{0,0,SB,0,32'h0,0, 0,0,0, A1,B1, 11},       // R11 strobe one cycle
        '{1,0,SH,C,32'h100,0, 0,0,0, A1,B1, 6},      // R6 no key, no reload
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B1, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B1, 2},
        '{1,0,SH,C,32'h200,0, 0,1,0, A1,B1, 4},      // R4 clear by bit 9
        '{0,1,SH,C,32'h0,0, 0,0,0, A1,B1, 4},
        '{0,0,SB,0,32'h0,1, 0,0,0, A1,B1, 4},
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B1, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B1, 2},
        '{1,0,SH,C,32'h1000,0, 0,1,0, A1,B1, 4},     // R4 clear by bit 12
        '{0,1,SH,C,32'h0,0, 0,0,0, A1,B1, 4},
        '{0,0,SB,0,32'h0,1, 0,0,0, A1,B1, 4},
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B1, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B1, 2},
        '{1,0,SW,C,32'h300,0, 0,0,0, A1,B1, 10},     // R10 word at command offset
        '{0,1,SH,C,32'h0,0, 0,0,RV,A1,B1, 10},       // R10 flag untouched
        '{1,0,SH,C,32'h100,0, 0,0,0, A1,B1, 10},     // R10 unlock was consumed
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B1, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B1, 2},
        '{1,0,SH,0,32'hAAA,0, 0,0,0, A1,B1, 10},     // R10 halfword at preload
        '{1,0,SW,0,32'hBBBBB,0, 0,0,0, A1,B1, 10},   // R10 consumed
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B1, 2},       // R2 opening key while closed
        '{1,0,SW,0,32'h111,0, 0,0,0, A1,B1, 2},
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B1, 1},
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B1, 1},       // R1 re-arm while armed
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B1, 1},
        '{1,0,SW,4,32'h222,0, 0,0,0, A1,B2, 1},
        '{1,0,SH,C,32'h80,0, 0,0,0, A1,B2, 2},
        '{1,0,SH,C,32'h11,0, 0,0,0, A1,B2, 2},       // R2 other write keeps armed
        '{1,0,SH,C,32'h86,0, 0,0,0, A1,B2, 2},
        '{1,0,SW,0,32'h333,0, 0,0,0, A2,B2, 2},
        '{1,0,SH,C,32'h80,0, 0,0,0, A2,B2, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A2,B2, 2},
        '{1,0,SH,C,32'h86,0, 0,0,0, A2,B2, 6},       // R6 key 2 while open consumes
        '{1,0,SW,0,32'h444,0, 0,0,0, A2,B2, 6},
        '{1,0,SH,C,32'h80,0, 0,0,0, A2,B2, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A2,B2, 2},
        '{1,0,SB,C,32'h86,0, 0,0,0, A2,B2, 7},       // R7 byte key while open
        '{1,0,SB,C,32'h01,0, 0,0,0, A2,B2, 7},
        '{1,0,SH,C,32'h100,0, 1,0,0, A2,B2, 7},
        '{1,0,SH,C,32'h80,0, 0,0,0, A2,B2, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A2,B2, 2},
        '{1,0,SH,C,32'h200,1, 0,1,0, A2,B2, 4},      // R4 set wins over clear
        '{0,1,SH,C,32'h0,0, 0,0,RV,A2,B2, 4},
        '{1,0,SH,C,32'h80,0, 0,0,0, A2,B2, 1},
        '{1,0,SH,C,32'h86,0, 0,0,0, A2,B2, 2},
        '{1,0,SH,C,32'h1300,0, 1,1,0, A2,B2, 3},     // R3 reload and clear together
        '{0,1,SH,C,32'h0,0, 0,0,0, A2,B2, 4}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic        rd_en;
    logic [3:0]  addr;
    logic [31:0] wdata;
    logic [1:0]  size;
    logic        cause_set;
    logic [31:0] rdata;
    logic [19:0] preload_a;
    logic [19:0] preload_b;
    logic        reload_pulse;
    logic        clear_pulse;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    keygate_unlock dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .size         (size),
        .cause_set    (cause_set),
        .rdata        (rdata),
        .preload_a    (preload_a),
        .preload_b    (preload_b),
        .reload_pulse (reload_pulse),
        .clear_pulse  (clear_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic r, input logic [1:0] s,
                         input logic [3:0] a, input logic [31:0] d, input logic cs);
        wr_en = w; rd_en = r; size = s; addr = a; wdata = d; cause_set = cs;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; size = SB; addr = '0; wdata = '0; cause_set = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset preload_a", {12'h0, preload_a}, {12'h0, F});
        chk("R9 reset preload_b", {12'h0, preload_b}, {12'h0, F});
        chk("R9 reset reload_pulse", {31'h0, reload_pulse}, 32'h0);
        chk("R9 reset clear_pulse", {31'h0, clear_pulse}, 32'h0);
        chk("R9 reset rdata", rdata, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            drive(v.wr, v.rd, v.sz, v.ad, v.dt, v.st);
            chk($sformatf("R%0d vec %0d reload", v.rq, i), {31'h0, reload_pulse}, {31'h0, v.er});
            chk($sformatf("R%0d vec %0d clear", v.rq, i), {31'h0, clear_pulse}, {31'h0, v.ec});
            chk($sformatf("R%0d vec %0d rdata", v.rq, i), rdata, v.erd);
            chk($sformatf("R%0d vec %0d preload_a", v.rq, i), {12'h0, preload_a}, {12'h0, v.epa});
            chk($sformatf("R%0d vec %0d preload_b", v.rq, i), {12'h0, preload_b}, {12'h0, v.epb});
        end

        // R9: reset while open with the flag set restores every default
        drive(1'b0, 1'b0, SB, 4'h0, 32'h0, 1'b1);
        drive(1'b1, 1'b0, SH, C, 32'h80, 1'b0);
        drive(1'b1, 1'b0, SH, C, 32'h86, 1'b0);
        drive(1'b1, 1'b0, SW, 4'h4, 32'h00ABC, 1'b0);
        chk("R5 preload_b load before reset", {12'h0, preload_b}, 32'h00ABC);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, SB, 4'h0, 32'h0, 1'b0);
        drive(1'b0, 1'b0, SB, 4'h0, 32'h0, 1'b0);
        chk("R9 mid-run reset preload_a", {12'h0, preload_a}, {12'h0, F});
        chk("R9 mid-run reset preload_b", {12'h0, preload_b}, {12'h0, F});
        rst_n = 1'b1;
        // R9: the gate is closed after reset, so this word write is ignored
        drive(1'b1, 1'b0, SW, 4'h0, 32'h00999, 1'b0);
        chk("R9 closed after reset", {12'h0, preload_a}, {12'h0, F});
        // R9: the flag was cleared by reset
        drive(1'b0, 1'b1, SH, C, 32'h0, 1'b0);
        chk("R9 flag cleared by reset", rdata, 32'h0);
        // R8: rdata returns to zero in a cycle without a read
        drive(1'b0, 1'b0, SB, 4'h0, 32'h0, 1'b1);
        drive(1'b0, 1'b1, SH, C, 32'h0, 1'b0);
        chk("R8 flag read after set", rdata, RV);
        drive(1'b0, 1'b0, SB, 4'h0, 32'h0, 1'b0);
        chk("R8 idle rdata", rdata, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule